// File: doc/BRIEF.md
# Stop-Mode Entry and Wakeup Sequencer

This block decides when a processor subsystem drops into one of two stop-class low-power modes and when it comes back. It watches the core's wait-for-interrupt, wait-for-event and return-from-handler strobes, together with the deep-sleep and sleep-on-exit enables and a 3-bit mode select. If the request qualifies and nothing is already pending, it gates the core clocks, the PLL and the oscillators, and asks the regulator for its low-power setting.

While the system is stopped, a per-line wake filter picks the lines that may end the stop. The filter depends on how the stop was entered and on the send-event-on-pending setting. When a line fires, the sequencer records the lowest such line and counts down a wakeup latency built from three configurable parts. It releases the core when that count reaches zero. In the deeper mode, a retain control bit decides whether the third memory bank keeps its contents.

All pins are plain control and status levels or single-cycle strobes. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `deepsleep_seq`

## Requirements
- R1: While running, a wait-for-interrupt or wait-for-event strobe with `deep_en_i`=1, mode code 3'b001 and nothing pending stops the core. `core_run_o` is 0 from the next clock edge on. If `deep_en_i`=0, the strobe has no effect.
- R2: A return-from-handler strobe stops the core only if both `deep_en_i` and `exit_sleep_en_i` are 1. Otherwise it has no effect.
- R3: If any bit of `line_pend_i` or `periph_wake_i` is 1 when an entry strobe arrives, the entry is dropped and `core_run_o` stays 1.
- R4: The mode select is sampled with the entry strobe. Only 3'b001 (stop one) and 3'b010 (stop two) enter a stop mode. Every other code leaves the core running.
- R5: After entry by wait-for-interrupt or return-from-handler, only lines with pending, interrupt-mode mask and interrupt-controller enable all equal to 1 end the stop.
- R6: After entry by wait-for-event with send-event-on-pending 0 (sampled at entry), any pending line whose event-mode mask bit is 1 ends the stop.
- R7: After entry by wait-for-event with send-event-on-pending 1, any pending line whose interrupt-mode mask bit is 1 ends the stop, whatever its interrupt-controller enable.
- R8: Let the wake line be seen at clock edge e. With T = max(osc, reg) + flash latency, sampled at e, `core_run_o` returns to 1 exactly at edge e+T.
- R9: While stopped, `clk_en_o`, `pll_en_o` and `osc_en_o` are 0 and `reg_lp_o` is 1. During the countdown, `osc_en_o` is 1 and `reg_lp_o` is 0, while `clk_en_o` and `pll_en_o` remain 0. While running, all three enables are 1 and `reg_lp_o` is 0.
- R10: `bank3_ret_o` is 1 (contents kept) except while stopped in stop two with the retain bit, sampled at entry, equal to 0.
- R11: At wakeup, `wake_cause_o` takes the index of the lowest-numbered line that ended the stop, and `wake_valid_o` is set. `wake_valid_o` clears on the next entry strobe of any kind while running, whether or not that strobe is accepted.
- R12: If both the wait-for-interrupt and wait-for-event strobes arrive together, the entry counts as wait-for-interrupt. Entry strobes are ignored while stopped or counting down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wfi_i | input | 1 | Wait-for-interrupt strobe |
| wfe_i | input | 1 | Wait-for-event strobe |
| eret_i | input | 1 | Return-from-handler strobe |
| deep_en_i | input | 1 | Deep-sleep enable |
| exit_sleep_en_i | input | 1 | Sleep-on-exit enable |
| mode_sel_i | input | 3 | Low-power mode code |
| sev_pend_en_i | input | 1 | Send-event-on-pending enable |
| bank3_keep_i | input | 1 | Retain third memory bank in stop two |
| periph_wake_i | input | 1 | Peripheral wakeup flag still set |
| line_pend_i | input | NL | Per-line pending flags |
| line_irq_mask_i | input | NL | Per-line interrupt-mode mask |
| line_evt_mask_i | input | NL | Per-line event-mode mask |
| irq_en_i | input | NL | Per-line interrupt-controller enable |
| osc_lat_i | input | LW | Oscillator wakeup cycles |
| reg_lat_i | input | LW | Regulator wakeup cycles |
| flash_lat_i | input | LW | Flash wakeup cycles |
| core_run_o | output | 1 | Core is running |
| clk_en_o | output | 1 | Core-domain clock enable |
| pll_en_o | output | 1 | PLL enable |
| osc_en_o | output | 1 | Oscillator enable |
| reg_lp_o | output | 1 | Regulator low-power request |
| bank3_ret_o | output | 1 | Third memory bank retention |
| wake_cause_o | output | IW | Index of the line that caused the last wakeup |
| wake_valid_o | output | 1 | `wake_cause_o` is valid |

## Verification
The bench builds the block with six lines and 4-bit latency fields. With six lines, random masks give a useful mix of empty, single-line and multi-line wake sets, and the lowest-index pick is exercised often. With 4-bit fields, every combined latency from zero up to thirty cycles can occur, including cases where the oscillator term is larger and cases where the regulator term is larger. Checking each countdown cycle by cycle stays cheap at that size.

// File: rtl/deepsleep_pkg.sv
package deepsleep_pkg;
  typedef enum logic [1:0] {ST_RUN, ST_STOP, ST_WARM} seq_state_t;
  typedef enum logic {ENT_IRQ, ENT_EVT} entry_kind_t;
  localparam logic [2:0] MODE_STOP1 = 3'b001;
  localparam logic [2:0] MODE_STOP2 = 3'b010;
endpackage

// File: rtl/dsq_entry_gate.sv
module dsq_entry_gate
  import deepsleep_pkg::*;
#(
  parameter int NL = 8
) (
  input  logic          wfi_i,
  input  logic          wfe_i,
  input  logic          eret_i,
  input  logic          deep_en_i,
  input  logic          exit_sleep_en_i,
  input  logic [2:0]    mode_sel_i,
  input  logic          periph_wake_i,
  input  logic [NL-1:0] line_pend_i,
  output logic          strobe_o,
  output logic          accept_o,
  output entry_kind_t   kind_o
);
  logic qualify, mode_ok, quiet;

  assign strobe_o = wfi_i | wfe_i | eret_i;
  assign qualify  = deep_en_i & (wfi_i | wfe_i | (eret_i & exit_sleep_en_i));
  assign mode_ok  = (mode_sel_i == MODE_STOP1) || (mode_sel_i == MODE_STOP2);
  assign quiet    = ~(|line_pend_i) & ~periph_wake_i;
  assign accept_o = qualify & mode_ok & quiet;

  // wait-for-interrupt wins a tie; wait-for-event next; handler return is interrupt-like
  always_comb begin
    if (wfi_i)      kind_o = ENT_IRQ;
    else if (wfe_i) kind_o = ENT_EVT;
    else            kind_o = ENT_IRQ;
  end
endmodule

// File: rtl/dsq_wake_pick.sv
module dsq_wake_pick
  import deepsleep_pkg::*;
#(
  parameter int NL = 8,
  localparam int IW = (NL > 1) ? $clog2(NL) : 1
) (
  input  entry_kind_t   kind_i,
  input  logic          sev_i,
  input  logic [NL-1:0] pend_i,
  input  logic [NL-1:0] irq_mask_i,
  input  logic [NL-1:0] evt_mask_i,
  input  logic [NL-1:0] irq_en_i,
  output logic          hit_o,
  output logic [IW-1:0] idx_o
);
  logic [NL-1:0] elig;

  for (genvar g = 0; g < NL; g++) begin : g_line
    always_comb begin
      if (kind_i == ENT_IRQ) elig[g] = pend_i[g] & irq_mask_i[g] & irq_en_i[g];
      else if (sev_i)        elig[g] = pend_i[g] & irq_mask_i[g];
      else                   elig[g] = pend_i[g] & evt_mask_i[g];
    end
  end

  assign hit_o = |elig;

  always_comb begin
    idx_o = '0;
    for (int i = NL - 1; i >= 0; i--) begin
      if (elig[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/dsq_wake_timer.sv
module dsq_wake_timer #(
  parameter int LW = 8,
  localparam int CW = LW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [LW-1:0] osc_lat_i,
  input  logic [LW-1:0] reg_lat_i,
  input  logic [LW-1:0] flash_lat_i,
  output logic          zero_total_o,
  output logic          last_o
);
  logic [CW-1:0] total, cnt_q;
  logic [LW-1:0] slow;

  assign slow         = (osc_lat_i > reg_lat_i) ? osc_lat_i : reg_lat_i;
  assign total        = {1'b0, slow} + {1'b0, flash_lat_i};
  assign zero_total_o = (total == '0);
  assign last_o       = (cnt_q == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load_i)       cnt_q <= total;
    else if (cnt_q != '0)  cnt_q <= cnt_q - CW'(1);
  end
endmodule

// File: rtl/deepsleep_seq.sv
module deepsleep_seq
  import deepsleep_pkg::*;
#(
  parameter int NL = 8,
  parameter int LW = 8,
  localparam int IW = (NL > 1) ? $clog2(NL) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wfi_i,
  input  logic          wfe_i,
  input  logic          eret_i,
  input  logic          deep_en_i,
  input  logic          exit_sleep_en_i,
  input  logic [2:0]    mode_sel_i,
  input  logic          sev_pend_en_i,
  input  logic          bank3_keep_i,
  input  logic          periph_wake_i,
  input  logic [NL-1:0] line_pend_i,
  input  logic [NL-1:0] line_irq_mask_i,
  input  logic [NL-1:0] line_evt_mask_i,
  input  logic [NL-1:0] irq_en_i,
  input  logic [LW-1:0] osc_lat_i,
  input  logic [LW-1:0] reg_lat_i,
  input  logic [LW-1:0] flash_lat_i,
  output logic          core_run_o,
  output logic          clk_en_o,
  output logic          pll_en_o,
  output logic          osc_en_o,
  output logic          reg_lp_o,
  output logic          bank3_ret_o,
  output logic [IW-1:0] wake_cause_o,
  output logic          wake_valid_o
);
  seq_state_t  state_q;
  entry_kind_t kind_q, kind_new;
  logic        sev_q, deep2_q, keep_q;
  logic        strobe, accept, hit, zero_total, last;
  logic [IW-1:0] idx, cause_q;
  logic        valid_q, load;

  dsq_entry_gate #(.NL(NL)) u_gate (
    .wfi_i(wfi_i), .wfe_i(wfe_i), .eret_i(eret_i),
    .deep_en_i(deep_en_i), .exit_sleep_en_i(exit_sleep_en_i),
    .mode_sel_i(mode_sel_i), .periph_wake_i(periph_wake_i),
    .line_pend_i(line_pend_i),
    .strobe_o(strobe), .accept_o(accept), .kind_o(kind_new)
  );

  dsq_wake_pick #(.NL(NL)) u_pick (
    .kind_i(kind_q), .sev_i(sev_q), .pend_i(line_pend_i),
    .irq_mask_i(line_irq_mask_i), .evt_mask_i(line_evt_mask_i),
    .irq_en_i(irq_en_i), .hit_o(hit), .idx_o(idx)
  );

  assign load = (state_q == ST_STOP) && hit;

  dsq_wake_timer #(.LW(LW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(load),
    .osc_lat_i(osc_lat_i), .reg_lat_i(reg_lat_i), .flash_lat_i(flash_lat_i),
    .zero_total_o(zero_total), .last_o(last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      kind_q  <= ENT_IRQ;
      sev_q   <= 1'b0;
      deep2_q <= 1'b0;
      keep_q  <= 1'b0;
      cause_q <= '0;
      valid_q <= 1'b0;
    end else begin
      case (state_q)
        ST_RUN: begin
          if (strobe) valid_q <= 1'b0;
          if (accept) begin
            state_q <= ST_STOP;
            kind_q  <= kind_new;
            sev_q   <= sev_pend_en_i;
            deep2_q <= (mode_sel_i == MODE_STOP2);
            keep_q  <= bank3_keep_i;
          end
        end
        ST_STOP: begin
          if (hit) begin
            cause_q <= idx;
            valid_q <= 1'b1;
            state_q <= zero_total ? ST_RUN : ST_WARM;
          end
        end
        ST_WARM: begin
          if (last) state_q <= ST_RUN;
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end

  assign core_run_o   = (state_q == ST_RUN);
  assign clk_en_o     = (state_q == ST_RUN);
  assign pll_en_o     = (state_q == ST_RUN);
  assign osc_en_o     = (state_q != ST_STOP);
  assign reg_lp_o     = (state_q == ST_STOP);
  assign bank3_ret_o  = !((state_q == ST_STOP) && deep2_q && !keep_q);
  assign wake_cause_o = cause_q;
  assign wake_valid_o = valid_q;
endmodule

// File: rtl/deepsleep_seq_checker.sv
module deepsleep_seq_checker #(
  parameter int NL = 8,
  localparam int IW = (NL > 1) ? $clog2(NL) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wfi_i,
  input logic          wfe_i,
  input logic          eret_i,
  input logic [2:0]    mode_sel_i,
  input logic          bank3_keep_i,
  input logic          periph_wake_i,
  input logic [NL-1:0] line_pend_i,
  input logic          core_run_o,
  input logic          clk_en_o,
  input logic          pll_en_o,
  input logic          osc_en_o,
  input logic          reg_lp_o,
  input logic          bank3_ret_o,
  input logic [IW-1:0] wake_cause_o,
  input logic          wake_valid_o
);
  logic [NL-1:0] pend_q;
  logic          any_strobe;

  assign any_strobe = wfi_i | wfe_i | eret_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= line_pend_i;
  end

  p_abort_r3: assert property (@(posedge clk) disable iff (!rst_n)
    core_run_o && any_strobe && ((|line_pend_i) || periph_wake_i) |=> core_run_o);

  p_bad_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    core_run_o && any_strobe && !(mode_sel_i == 3'b001 || mode_sel_i == 3'b010) |=> core_run_o);

  p_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !core_run_o && !osc_en_o |-> !clk_en_o && !pll_en_o && reg_lp_o);

  p_bank_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_run_o) && $past(mode_sel_i == 3'b010 && !bank3_keep_i) |-> !bank3_ret_o);

  p_cause_pending_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_valid_o) |-> pend_q[wake_cause_o]);

  p_valid_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    core_run_o && any_strobe |=> !wake_valid_o);

  p_run_after_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_run_o) |-> wake_valid_o);
endmodule

bind deepsleep_seq deepsleep_seq_checker #(.NL(NL)) u_chk (
  .clk(clk), .rst_n(rst_n), .wfi_i(wfi_i), .wfe_i(wfe_i), .eret_i(eret_i),
  .mode_sel_i(mode_sel_i), .bank3_keep_i(bank3_keep_i),
  .periph_wake_i(periph_wake_i), .line_pend_i(line_pend_i),
  .core_run_o(core_run_o), .clk_en_o(clk_en_o), .pll_en_o(pll_en_o),
  .osc_en_o(osc_en_o), .reg_lp_o(reg_lp_o), .bank3_ret_o(bank3_ret_o),
  .wake_cause_o(wake_cause_o), .wake_valid_o(wake_valid_o)
);

// File: tb/deepsleep_seq_test.sv
module deepsleep_seq_test;
  localparam int NL = 6;
  localparam int LW = 4;
  localparam int IW = $clog2(NL);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wfi = 0, wfe = 0, eret = 0, deep_en = 1, exit_en = 1;
  logic [2:0] mode = 3'b001;
  logic sev = 0, keep = 0, pflag = 0;
  logic [NL-1:0] pend = '0, imask = '0, emask = '0, ien = '0;
  logic [LW-1:0] osc = '0, rgl = '0, fl = '0;
  logic core_run, clk_en, pll_en, osc_en, reg_lp, bret, wvalid;
  logic [IW-1:0] wcause;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  deepsleep_seq #(.NL(NL), .LW(LW)) uut (
    .clk(clk), .rst_n(rst_n), .wfi_i(wfi), .wfe_i(wfe), .eret_i(eret),
    .deep_en_i(deep_en), .exit_sleep_en_i(exit_en), .mode_sel_i(mode),
    .sev_pend_en_i(sev), .bank3_keep_i(keep), .periph_wake_i(pflag),
    .line_pend_i(pend), .line_irq_mask_i(imask), .line_evt_mask_i(emask),
    .irq_en_i(ien), .osc_lat_i(osc), .reg_lat_i(rgl), .flash_lat_i(fl),
    .core_run_o(core_run), .clk_en_o(clk_en), .pll_en_o(pll_en),
    .osc_en_o(osc_en), .reg_lp_o(reg_lp), .bank3_ret_o(bret),
    .wake_cause_o(wcause), .wake_valid_o(wvalid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NL-1:0] f_elig(input bit evt_kind, input bit s,
      input logic [NL-1:0] p, im, em, ie);
    if (!evt_kind) return p & im & ie;
    if (s)         return p & im;
    return p & em;
  endfunction

  function automatic int f_low(input logic [NL-1:0] v);
    for (int i = 0; i < NL; i++) if (v[i]) return i;
    return 0;
  endfunction

  function automatic int f_lat(input int o, input int r, input int f);
    return ((o > r) ? o : r) + f;
  endfunction

  // drive strobes for one cycle; returns at the negedge after the sampling edge
  task automatic pulse(input bit a, input bit b, input bit c);
    @(negedge clk); wfi = a; wfe = b; eret = c;
    @(negedge clk); wfi = 0; wfe = 0; eret = 0;
  endtask

  // pending set by caller at the current negedge; checks countdown and release
  task automatic measure(input string req, input int cause);
    int t;
    t = f_lat(osc, rgl, fl);
    for (int k = 0; k < t; k++) begin
      @(negedge clk);
      check({req, "/R8 counting"}, core_run, 0);
      if (k == 0) begin
        check("R9 warm osc on", osc_en, 1);
        check("R9 warm clk off", clk_en, 0);
      end
    end
    @(negedge clk);
    check({req, "/R8 released"}, core_run, 1);
    check("R11 cause", wcause, cause);
    check("R11 valid", wvalid, 1);
    check("R9 run enables", {clk_en, pll_en, osc_en, reg_lp}, 4'b1110);
    pend = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R9 reset enables", {clk_en, pll_en, osc_en, reg_lp}, 4'b1110);
    check("R1 reset running", core_run, 1);
    check("R10 reset retention", bret, 1);
    check("R11 reset valid", wvalid, 0);

    // R3: pending line or peripheral flag aborts entry
    pend = 6'b000100;
    pulse(1, 0, 0);
    check("R3 pending abort", core_run, 1);
    pend = '0; pflag = 1;
    pulse(0, 1, 0);
    check("R3 peripheral abort", core_run, 1);
    pflag = 0;

    // R4: unsupported mode codes
    mode = 3'b011; pulse(1, 0, 0);
    check("R4 code 011", core_run, 1);
    mode = 3'b000; pulse(0, 1, 0);
    check("R4 code 000", core_run, 1);
    mode = 3'b001;

    // R1: deep-sleep enable cleared
    deep_en = 0; pulse(1, 0, 0);
    check("R1 no deep enable", core_run, 1);
    deep_en = 1;

    // R2: return from handler needs sleep-on-exit
    exit_en = 0; pulse(0, 0, 1);
    check("R2 exit disabled", core_run, 1);
    exit_en = 1; pulse(0, 0, 1);
    check("R2 exit enabled", core_run, 0);
    check("R9 stopped enables", {clk_en, pll_en, osc_en, reg_lp}, 4'b0001);
    imask = 6'b010010; ien = 6'b010010; osc = 3; rgl = 5; fl = 2;
    @(negedge clk); pend = 6'b010010;
    measure("R5 two lines lowest", 1);

    // R11: rejected strobe still clears valid
    deep_en = 0; pulse(1, 0, 0);
    check("R11 cleared by strobe", wvalid, 0);
    deep_en = 1;

    // R12: simultaneous strobes count as interrupt entry; strobes while stopped ignored
    imask = '0; ien = '0; emask = 6'b001000; osc = 0; rgl = 0; fl = 0;
    pulse(1, 1, 0);
    check("R12 entered", core_run, 0);
    pend = 6'b001000;
    repeat (3) @(negedge clk);
    check("R12 event line ignored", core_run, 0);
    pend = '0;
    pulse(1, 1, 1);
    @(negedge clk);
    check("R12 strobe while stopped", core_run, 0);
    imask = 6'b100000; ien = 6'b100000; pend = 6'b100000;
    measure("R12 zero latency wake", 5);

    // R10: stop two retention
    mode = 3'b010; keep = 0; pulse(1, 0, 0);
    check("R10 stop two dropped", bret, 0);
    keep = 1;
    @(negedge clk);
    check("R10 keep sampled at entry", bret, 0);
    pend = 6'b100000; rgl = 7;
    measure("R5 stop two wake", 5);
    keep = 1; pulse(1, 0, 0);
    check("R10 stop two kept", bret, 1);
    pend = 6'b100000;
    measure("R5 kept wake", 5);

    // random mix
    for (int it = 0; it < 60; it++) begin
      int kind;
      logic [NL-1:0] el;
      string tag;
      kind = int'($urandom % 3);
      sev = 1'($urandom); keep = 1'($urandom);
      mode = ($urandom % 2) ? 3'b010 : 3'b001;
      imask = NL'($urandom); emask = NL'($urandom); ien = NL'($urandom);
      osc = LW'($urandom); rgl = LW'($urandom); fl = LW'($urandom);
      pulse(kind == 0, kind == 1, kind == 2);
      check("R1 random entry", core_run, 0);
      check("R10 random retention", bret, !(mode == 3'b010 && !keep));
      tag = (kind == 1) ? (sev ? "R7" : "R6") : "R5";
      pend = NL'($urandom);
      el = f_elig(kind == 1, sev, pend, imask, emask, ien);
      if (el == '0) begin
        repeat (3) @(negedge clk);
        check({tag, " not eligible"}, core_run, 0);
        begin
          int j;
          j = int'($urandom % NL);
          pend[j] = 1; imask[j] = 1; emask[j] = 1; ien[j] = 1;
        end
        el = f_elig(kind == 1, sev, pend, imask, emask, ien);
      end
      measure(tag, f_low(el));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule